// File: doc/BRIEF.md
# Per-Channel DC Offset Detector

This block watches a digital estimate of the DC offset at the output of each of several amplifier channels while the amplifier plays. Every channel delivers one signed two's-complement offset sample per clock. When the absolute value of a channel's offset stays at or above a programmable level for a programmable number of slow time ticks, that channel's detect flag is set. Detection runs all the time, not only during a diagnostic pass.

By default a detection is only reported. When the shutdown-enable input is high, a detection also raises a shutdown request for the triggered channel alone, so the other channels keep playing. The shared fault output is raised while any shutdown request is set. Flags and requests are sticky until software pulses the clear bit for that channel. The threshold, duration and shutdown-enable come from configuration registers outside the block.

Top module: `dc_offset_monitor`

## Requirements
- R1: A channel is "over" in a cycle when the absolute value of its signed sample is greater than or equal to `level`, taken as an unsigned number. The most negative sample has a magnitude of 2^(SAMPLE_W-1).
- R2: Each channel has its own duration counter. The counter goes up by one, saturating, at each edge where the channel is over and `tick` is high. It returns to zero at any edge where the channel is not over.
- R3: `detect[i]` is set at an edge where channel i is over and its count after that edge's update is at least `duration`. With `tick` high every cycle, the flag becomes visible after the `duration`-th consecutive over edge.
- R4: With `duration` of 1 or more and `tick` low, an over channel never triggers, however long the offset lasts.
- R5: When `duration` is 0, a channel triggers at its first over edge even while `tick` is low.
- R6: `detect[i]` is sticky until `clear[i]` is high at an edge, which forces it to 0. Clear wins over a trigger at the same edge and leaves the counter untouched, so an offset that is still present sets the flag again at the next edge.
- R7: `shutdown_req[i]` is set together with `detect[i]` only if `shutdown_en` is high at that edge. With `shutdown_en` low, which is the register's reset value, no shutdown is requested. `shutdown_req[i]` is sticky and is cleared by `clear[i]`.
- R8: Channels are independent. A trigger on one channel sets only that channel's bits of `detect` and `shutdown_req`.
- R9: `fault` is high in exactly the cycles where at least one `shutdown_req` bit is high. A detection without shutdown leaves `fault` low.
- R10: A synchronous active-high `rst` clears all flags, requests, `fault` and the counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| samples | input | NUM_CH*SAMPLE_W | Packed signed offset samples; channel i at bits [i*SAMPLE_W +: SAMPLE_W] |
| tick | input | 1 | Slow time-base enable pulse for the duration counters |
| level | input | SAMPLE_W | Unsigned magnitude threshold |
| duration | input | DUR_W | Required number of ticks at or above the threshold |
| shutdown_en | input | 1 | Enables per-channel shutdown on detection |
| clear | input | NUM_CH | Per-channel clear strobe for the sticky flags |
| detect | output | NUM_CH | Sticky per-channel detect flags |
| shutdown_req | output | NUM_CH | Sticky per-channel shutdown requests |
| fault | output | 1 | Shared fault output |

## Verification
On every cycle, the assertions check these rules:
- a counter is zero one cycle after its channel drops below the threshold;
- a flag rises only after an over cycle;
- a shutdown request rises only when enabled and never stands without its detect flag;
- clear empties both flags;
- `fault` matches the OR of the shutdown requests.

The exact trigger cycle for a given duration, and the absolute-value handling of negative and extreme samples, can only be shown by the bench's scenarios. The same holds for counter restarts after a short dip, tick gating, the zero-duration case and clear priority over a persisting offset.

// File: rtl/dcdet_pkg.sv
package dcdet_pkg;

  // Magnitude of a signed two's-complement value, returned unsigned at the
  // same width; the most negative value maps to 2^(W-1) without overflow.
  function automatic logic [31:0] magnitude32(input logic [31:0] v, input int w);
    logic [31:0] m;
    m = v[w-1] ? (~v + 32'd1) : v;
    return m & ((32'd1 << w) - 32'd1);
  endfunction

endpackage

// File: rtl/dcdet_mag.sv
module dcdet_mag #(
  parameter int SAMPLE_W = 16
) (
  input  logic [SAMPLE_W-1:0] sample,
  input  logic [SAMPLE_W-1:0] level,
  output logic                over
);
  import dcdet_pkg::*;

  localparam int PAD_W = 32 - SAMPLE_W;

  logic [31:0] sample_ext;
  logic [31:0] mag32;
  logic [SAMPLE_W-1:0] mag;

  always_comb begin
    sample_ext = {{PAD_W{sample[SAMPLE_W-1]}}, sample};
    mag32      = magnitude32(sample_ext, SAMPLE_W);
    mag        = mag32[SAMPLE_W-1:0];
    over       = (mag >= level);
  end

endmodule

// File: rtl/dcdet_chan.sv
module dcdet_chan #(
  parameter int DUR_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             over,
  input  logic             tick,
  input  logic [DUR_W-1:0] duration,
  input  logic             shutdown_en,
  input  logic             clr,
  output logic             det,
  output logic             shut,
  output logic             shut_nxt
);
  localparam logic [DUR_W-1:0] CNT_MAX = {DUR_W{1'b1}};

  logic [DUR_W-1:0] cnt_q;
  logic [DUR_W-1:0] cnt_upd;
  logic             trig;
  logic             det_q, shut_q;
  logic             det_nxt;

  always_comb begin
    if (tick && cnt_q != CNT_MAX) cnt_upd = cnt_q + 1'b1;
    else                          cnt_upd = cnt_q;
    trig = over && (cnt_upd >= duration);
    if (clr) begin
      det_nxt  = 1'b0;
      shut_nxt = 1'b0;
    end else begin
      det_nxt  = det_q  | trig;
      shut_nxt = shut_q | (trig & shutdown_en);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      det_q  <= 1'b0;
      shut_q <= 1'b0;
    end else begin
      cnt_q  <= over ? cnt_upd : '0;
      det_q  <= det_nxt;
      shut_q <= shut_nxt;
    end
  end

  assign det  = det_q;
  assign shut = shut_q;

  // R2
  cnt_restart_chk: assert property (@(posedge clk) disable iff (rst)
    !over |=> (cnt_q == '0));

  // R3
  det_needs_over_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(det_q) |-> $past(over));

  // R6
  clear_empties_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!det_q && !shut_q));

  // R7
  shut_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(shut_q) |-> $past(shutdown_en));

  // R7
  shut_implies_det_chk: assert property (@(posedge clk) disable iff (rst)
    shut_q |-> det_q);

endmodule

// File: rtl/dc_offset_monitor.sv
module dc_offset_monitor #(
  parameter int NUM_CH   = 4,
  parameter int SAMPLE_W = 16,
  parameter int DUR_W    = 12
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_CH*SAMPLE_W-1:0] samples,
  input  logic                       tick,
  input  logic [SAMPLE_W-1:0]        level,
  input  logic [DUR_W-1:0]           duration,
  input  logic                       shutdown_en,
  input  logic [NUM_CH-1:0]          clear,
  output logic [NUM_CH-1:0]          detect,
  output logic [NUM_CH-1:0]          shutdown_req,
  output logic                       fault
);
  logic [NUM_CH-1:0] over_v;
  logic [NUM_CH-1:0] shut_nxt_v;
  logic              fault_q;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    dcdet_mag #(.SAMPLE_W(SAMPLE_W)) u_mag (
      .sample (samples[i*SAMPLE_W +: SAMPLE_W]),
      .level  (level),
      .over   (over_v[i])
    );

    dcdet_chan #(.DUR_W(DUR_W)) u_chan (
      .clk         (clk),
      .rst         (rst),
      .over        (over_v[i]),
      .tick        (tick),
      .duration    (duration),
      .shutdown_en (shutdown_en),
      .clr         (clear[i]),
      .det         (detect[i]),
      .shut        (shutdown_req[i]),
      .shut_nxt    (shut_nxt_v[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) fault_q <= 1'b0;
    else     fault_q <= |shut_nxt_v;
  end

  assign fault = fault_q;

  // R9
  fault_tracks_shut_chk: assert property (@(posedge clk) disable iff (rst)
    fault == (|shutdown_req));

endmodule

// File: tb/tb_dc_offset_monitor.sv
module tb_dc_offset_monitor;
  localparam int NUM_CH = 4;
  localparam int SW     = 16;
  localparam int DW     = 12;
  localparam int NVEC   = 8;

  // vector table: sample, level, duration, edges, expected detect[0]
  localparam int V_SAMP [NVEC] = '{100, -100, 100, -49, 50, -32768, 32767, -50};
  localparam int V_LEVL [NVEC] = '{50, 50, 50, 50, 50, 1000, 32767, 50};
  localparam int V_DUR  [NVEC] = '{3, 3, 3, 1, 2, 1, 1, 4};
  localparam int V_N    [NVEC] = '{3, 3, 2, 5, 2, 1, 1, 4};
  localparam int V_EXP  [NVEC] = '{1, 1, 0, 0, 1, 1, 1, 1};

  logic clk = 1'b0;
  logic rst;
  logic [SW-1:0] s [NUM_CH];
  logic [NUM_CH*SW-1:0] samples;
  logic tick;
  logic [SW-1:0] level;
  logic [DW-1:0] duration;
  logic shutdown_en;
  logic [NUM_CH-1:0] clear;
  logic [NUM_CH-1:0] detect, shutdown_req;
  logic fault;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  assign samples = {s[3], s[2], s[1], s[0]};

  dc_offset_monitor #(.NUM_CH(NUM_CH), .SAMPLE_W(SW), .DUR_W(DW)) dut (
    .clk(clk), .rst(rst), .samples(samples), .tick(tick), .level(level),
    .duration(duration), .shutdown_en(shutdown_en), .clear(clear),
    .detect(detect), .shutdown_req(shutdown_req), .fault(fault)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic zero_all();
    for (int i = 0; i < NUM_CH; i++) s[i] = '0;
  endtask

  // clear every channel and restart counters with all samples at zero
  task automatic restart();
    zero_all();
    clear = '1;
    step(1);
    clear = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    rst = 1'b1; tick = 1'b1; level = 16'd50; duration = 12'd3;
    shutdown_en = 1'b0; clear = '0;
    zero_all();
    @(negedge clk);
    step(2);
    // R10 reset state
    chk("R10 detect", detect, 0);
    chk("R10 shutdown_req", shutdown_req, 0);
    chk("R10 fault", fault, 0);
    rst = 1'b0;

    // R1 R3 table walk on channel 0
    for (int v = 0; v < NVEC; v++) begin
      level = V_LEVL[v][SW-1:0];
      duration = V_DUR[v][DW-1:0];
      tick = 1'b1;
      restart();
      s[0] = V_SAMP[v][SW-1:0];
      step(V_N[v]);
      chk($sformatf("R1/R3 vector %0d", v), detect[0], V_EXP[v]);
    end

    // R2 a dip below level restarts the count
    level = 16'd50; duration = 12'd3; tick = 1'b1;
    restart();
    s[0] = 16'd100; step(2);
    chk("R2 no trigger before dip", detect[0], 0);
    s[0] = 16'd10; step(1);
    s[0] = 16'd100; step(2);
    chk("R2 count restarted after dip", detect[0], 0);
    step(1);
    chk("R2 trigger after full run", detect[0], 1);

    // R4 no progress without tick
    duration = 12'd2; tick = 1'b0;
    restart();
    s[0] = 16'd100; step(10);
    chk("R4 no tick no trigger", detect[0], 0);
    tick = 1'b1; step(1);
    chk("R4 one tick not enough", detect[0], 0);
    step(1);
    chk("R4 second tick triggers", detect[0], 1);

    // R5 duration zero triggers immediately
    duration = 12'd0; tick = 1'b0;
    restart();
    s[0] = 16'd100; step(1);
    chk("R5 zero duration", detect[0], 1);

    // R6 sticky and clear priority
    duration = 12'd2; tick = 1'b1;
    restart();
    s[0] = 16'd100; step(2);
    chk("R6 set", detect[0], 1);
    s[0] = 16'd0; step(3);
    chk("R6 sticky after offset gone", detect[0], 1);
    clear = 4'b0001; step(1); clear = '0;
    chk("R6 cleared", detect[0], 0);
    s[0] = 16'd100; step(2);
    clear = 4'b0001; step(1); clear = '0;
    chk("R6 clear wins over trigger", detect[0], 0);
    step(1);
    chk("R6 persisting offset retriggers", detect[0], 1);

    // R7 R9 shutdown disabled
    duration = 12'd1; shutdown_en = 1'b0;
    restart();
    s[1] = 16'hFF00; step(1);
    chk("R7 detect without shutdown", detect, 4'b0010);
    chk("R7 no shutdown when disabled", shutdown_req, 0);
    chk("R9 no fault on detect only", fault, 0);

    // R7 R8 R9 shutdown enabled, only channel 2
    shutdown_en = 1'b1;
    restart();
    s[2] = 16'd200; step(1);
    chk("R8 only channel 2 detects", detect, 4'b0100);
    chk("R7 R8 only channel 2 shut", shutdown_req, 4'b0100);
    chk("R9 fault raised", fault, 1);
    shutdown_en = 1'b0; s[2] = '0; step(2);
    chk("R7 shutdown sticky", shutdown_req, 4'b0100);
    clear = 4'b0100; step(1); clear = '0;
    chk("R7 shutdown cleared", shutdown_req, 0);
    chk("R9 fault dropped", fault, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule